// File: doc/BRIEF.md
# Dispatch Group Slot Controller

This block sits between instruction decode and the scheduling and retirement back end. It keeps a budget of dispatch slots for each dispatch cycle and decides, for the instruction offered on a valid/ready input, whether that instruction can leave this cycle. Several handshakes may fall inside one dispatch cycle. The `cyc_start` pin marks the clock on which a new dispatch cycle begins, and the slot budget is refreshed on that clock. An instruction needs as many slots as its micro-op count, up to the dispatch width. An instruction flagged to open a group may only take a fresh cycle. An instruction flagged to close a group uses up whatever slots remain.

An instruction with more micro-ops than the dispatch width takes a whole empty cycle. Its excess micro-ops are carried into the following dispatch cycles and reported on a separate pair of outputs. The block stores no instructions. `in_ready` is a combinational function of the current state and the offered fields, and the instruction is consumed on any clock where `in_valid` and `in_ready` are both high. The source must hold the instruction stable while `in_ready` is low. Three back-end checks gate acceptance, and a 2-bit stall code names the first check that fails.

Top module: `disp_slot_ctrl`

## Requirements
- R1: After synchronous active-high reset, no carry-over is pending and all DISP_W slots (default 4) are available, even before the first `cyc_start`.
- R2: On a `cyc_start` clock with no carry-over pending, the available slot count is DISP_W, and `carry_vld` stays low.
- R3: An instruction needs min(`in_uops`, DISP_W) slots. It is refused (`in_ready` low, `stall` 0) when that exceeds the slots still available, and an accepted one subtracts that many slots.
- R4: An instruction with `in_begin` high is accepted only while all DISP_W slots of the cycle are still available.
- R5: Accepting an instruction with `in_end` high leaves zero slots for the rest of the dispatch cycle.
- R6: An instruction with `in_uops` > DISP_W is accepted only into a fully empty cycle. It reports DISP_W micro-ops, uses every slot, and records `in_uops` − DISP_W as the carry-over.
- R7: On a `cyc_start` clock with carry-over C pending, `carry_vld` is high and `carry_uops` = min(C, DISP_W). C is reduced by that amount, and the cycle starts with DISP_W − min(C, DISP_W) available slots.
- R8: No new instruction is accepted while carry-over remains pending after the current clock's reduction.
- R9: Once the slot rules pass, the checks run in a fixed order: retire room, register room, next stage ready. `stall` reports the first failure as 1, 2 or 3. `stall` is 0 when the checks all pass, when `in_valid` is low, or when the slot rules refuse the instruction.
- R10: The retire-room check compares the full `in_uops`, not the slot need, against `rob_free`.
- R11: `disp` is high exactly on handshake clocks. `disp_uops` is then min(`in_uops`, DISP_W), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | First clock of a new dispatch cycle |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be dispatched now |
| in_uops | input | UOP_W | Micro-op count of the offered instruction |
| in_begin | input | 1 | Instruction must open a dispatch group |
| in_end | input | 1 | Instruction closes the dispatch group |
| rob_free | input | ROB_W | Free retire-buffer entries |
| rf_ok | input | 1 | Register files have room for all destinations |
| nxt_ok | input | 1 | Next stage can accept |
| disp | output | 1 | Instruction dispatched this clock |
| disp_uops | output | CNT_W | Micro-ops reported for the dispatched instruction |
| carry_vld | output | 1 | Carried-over micro-ops reported this clock |
| carry_uops | output | CNT_W | Number of carried micro-ops reported |
| stall | output | 2 | Stall reason: 0 none, 1 retire, 2 register, 3 next stage |

## Verification
Slot packing is exercised with several instructions of mixed sizes inside one cycle, so that an exact fit can be told apart from an overrun by one slot. Group flags are offered both at a fresh cycle and after a used slot, which separates a correct begin/end rule from a missing one. Oversized instructions are run with carries both above and below the width. This checks the drain arithmetic and the point where new instructions become admissible. Stall patterns fail several checks together, which exposes the priority order, and a retire room that covers the slot need but not the full count shows which count the retire check uses.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    STALL_NONE   = 2'd0,
    STALL_RETIRE = 2'd1,
    STALL_REGS   = 2'd2,
    STALL_NEXT   = 2'd3
  } stall_e;
endpackage

// File: rtl/dsc_budget.sv
module dsc_budget #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  localparam int CNT_W = $clog2(DISP_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_start,
  input  logic             fire,
  input  logic             fire_big,
  input  logic             fire_end,
  input  logic [CNT_W-1:0] fire_need,
  input  logic [UOP_W-1:0] in_uops,
  output logic [CNT_W-1:0] cur_avail,
  output logic             pending,
  output logic             carry_vld,
  output logic [CNT_W-1:0] carry_uops
);
  localparam logic [UOP_W-1:0] W_U = UOP_W'(DISP_W);
  localparam logic [CNT_W-1:0] W_C = CNT_W'(DISP_W);

  logic [CNT_W-1:0] avail_q, avail_d, start_avail, carry_take;
  logic [UOP_W-1:0] carry_q, carry_d, carry_left;

  always_comb begin
    start_avail = (carry_q >= W_U) ? '0 : CNT_W'(W_U - carry_q);
    cur_avail   = cyc_start ? start_avail : avail_q;
    carry_take  = cyc_start ? (W_C - start_avail) : '0;
    carry_left  = carry_q - UOP_W'(carry_take);
    pending     = (carry_left != '0);
    carry_vld   = cyc_start && (carry_q != '0);
    carry_uops  = carry_take;
  end

  always_comb begin
    avail_d = cur_avail;
    carry_d = carry_left;
    if (fire) begin
      avail_d = (fire_big || fire_end) ? '0 : (cur_avail - fire_need);
      if (fire_big) carry_d = in_uops - W_U;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= W_C;
      carry_q <= '0;
    end else begin
      avail_q <= avail_d;
      carry_q <= carry_d;
    end
  end
endmodule

// File: rtl/dsc_admit.sv
module dsc_admit #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  localparam int CNT_W = $clog2(DISP_W + 1)
) (
  input  logic [UOP_W-1:0] in_uops,
  input  logic             in_begin,
  input  logic [CNT_W-1:0] cur_avail,
  input  logic             pending,
  output logic [CNT_W-1:0] need,
  output logic             big,
  output logic             slot_ok
);
  localparam logic [UOP_W-1:0] W_U = UOP_W'(DISP_W);
  localparam logic [CNT_W-1:0] W_C = CNT_W'(DISP_W);

  logic fresh;

  always_comb begin
    big     = (in_uops > W_U);
    need    = big ? W_C : CNT_W'(in_uops);
    fresh   = (cur_avail == W_C);
    slot_ok = !pending && (need <= cur_avail) &&
              (!in_begin || fresh) && (!big || fresh);
  end
endmodule

// File: rtl/dsc_resource.sv
module dsc_resource #(
  parameter int UOP_W = 4,
  parameter int ROB_W = 6
) (
  input  logic [UOP_W-1:0] in_uops,
  input  logic [ROB_W-1:0] rob_free,
  input  logic             rf_ok,
  input  logic             nxt_ok,
  input  logic             in_valid,
  input  logic             slot_ok,
  output logic             res_ok,
  output logic [1:0]       stall
);
  import dsc_pkg::*;
  localparam int CMP_W  = (ROB_W > UOP_W) ? ROB_W : UOP_W;
  localparam int N_CHK  = 3;

  logic [N_CHK-1:0] fail;
  stall_e           codes [N_CHK];
  stall_e           first;

  assign codes[0] = STALL_RETIRE;
  assign codes[1] = STALL_REGS;
  assign codes[2] = STALL_NEXT;

  always_comb begin
    fail[0] = CMP_W'(rob_free) < CMP_W'(in_uops);
    fail[1] = !rf_ok;
    fail[2] = !nxt_ok;
    res_ok  = (fail == '0);
    first   = STALL_NONE;
    for (int i = N_CHK - 1; i >= 0; i--) begin
      if (fail[i]) first = codes[i];
    end
    stall = (in_valid && slot_ok) ? first : STALL_NONE;
  end
endmodule

// File: rtl/disp_slot_ctrl.sv
module disp_slot_ctrl #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int ROB_W  = 6,
  localparam int CNT_W = $clog2(DISP_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [UOP_W-1:0] in_uops,
  input  logic             in_begin,
  input  logic             in_end,
  input  logic [ROB_W-1:0] rob_free,
  input  logic             rf_ok,
  input  logic             nxt_ok,
  output logic             disp,
  output logic [CNT_W-1:0] disp_uops,
  output logic             carry_vld,
  output logic [CNT_W-1:0] carry_uops,
  output logic [1:0]       stall
);
  logic [CNT_W-1:0] cur_avail, need;
  logic             pending, big, slot_ok, res_ok;

  dsc_budget #(.DISP_W(DISP_W), .UOP_W(UOP_W)) u_budget (
    .clk(clk), .rst(rst), .cyc_start(cyc_start),
    .fire(disp), .fire_big(big), .fire_end(in_end), .fire_need(need),
    .in_uops(in_uops), .cur_avail(cur_avail), .pending(pending),
    .carry_vld(carry_vld), .carry_uops(carry_uops)
  );

  dsc_admit #(.DISP_W(DISP_W), .UOP_W(UOP_W)) u_admit (
    .in_uops(in_uops), .in_begin(in_begin), .cur_avail(cur_avail),
    .pending(pending), .need(need), .big(big), .slot_ok(slot_ok)
  );

  dsc_resource #(.UOP_W(UOP_W), .ROB_W(ROB_W)) u_res (
    .in_uops(in_uops), .rob_free(rob_free), .rf_ok(rf_ok), .nxt_ok(nxt_ok),
    .in_valid(in_valid), .slot_ok(slot_ok), .res_ok(res_ok), .stall(stall)
  );

  assign in_ready  = slot_ok && res_ok;
  assign disp      = in_valid && in_ready;
  assign disp_uops = disp ? need : '0;
endmodule

// File: rtl/dsc_chk.sv
module dsc_chk #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int ROB_W  = 6,
  localparam int CNT_W = $clog2(DISP_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_start,
  input logic             in_valid,
  input logic             in_ready,
  input logic [UOP_W-1:0] in_uops,
  input logic             in_end,
  input logic [ROB_W-1:0] rob_free,
  input logic             disp,
  input logic [CNT_W-1:0] disp_uops,
  input logic             carry_vld,
  input logic [CNT_W-1:0] carry_uops,
  input logic [1:0]       stall
);
  // R8
  oversize_blocks_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (disp && (in_uops > UOP_W'(DISP_W))) |=> (cyc_start || !disp));
  // R5
  end_group_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (disp && in_end) |=> (cyc_start || !disp));
  // R9
  stall_no_disp_chk: assert property (@(posedge clk) disable iff (rst)
    (stall != 2'd0) |-> !disp);
  // R11
  disp_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    disp |-> (disp_uops <= CNT_W'(DISP_W)));
  // R7
  carry_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    carry_vld |-> (carry_uops != '0 && carry_uops <= CNT_W'(DISP_W)));
  // R10
  retire_room_chk: assert property (@(posedge clk) disable iff (rst)
    disp |-> ((ROB_W + UOP_W)'(rob_free) >= (ROB_W + UOP_W)'(in_uops)));
  // R11
  ready_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> disp);
endmodule

bind disp_slot_ctrl dsc_chk #(.DISP_W(DISP_W), .UOP_W(UOP_W), .ROB_W(ROB_W)) u_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .in_valid(in_valid),
  .in_ready(in_ready), .in_uops(in_uops), .in_end(in_end), .rob_free(rob_free),
  .disp(disp), .disp_uops(disp_uops), .carry_vld(carry_vld),
  .carry_uops(carry_uops), .stall(stall)
);

// File: tb/disp_slot_ctrl_test.sv
module disp_slot_ctrl_test;
  localparam int DISP_W = 4;
  localparam int UOP_W  = 4;
  localparam int ROB_W  = 6;
  localparam int CNT_W  = $clog2(DISP_W + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0, in_valid = 1'b0, in_begin = 1'b0, in_end = 1'b0;
  logic rf_ok = 1'b1, nxt_ok = 1'b1;
  logic [UOP_W-1:0] in_uops = '0;
  logic [ROB_W-1:0] rob_free = '1;
  logic in_ready, disp, carry_vld;
  logic [CNT_W-1:0] disp_uops, carry_uops;
  logic [1:0] stall;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  disp_slot_ctrl #(.DISP_W(DISP_W), .UOP_W(UOP_W), .ROB_W(ROB_W)) uut (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_uops(in_uops), .in_begin(in_begin), .in_end(in_end),
    .rob_free(rob_free), .rf_ok(rf_ok), .nxt_ok(nxt_ok), .disp(disp),
    .disp_uops(disp_uops), .carry_vld(carry_vld), .carry_uops(carry_uops),
    .stall(stall)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one clock's inputs at the falling edge, settle, then checks follow
  task automatic put(input logic cs, input logic v, input int u,
                     input logic b = 1'b0, input logic e = 1'b0,
                     input int rob = 63, input logic rf = 1'b1, input logic nx = 1'b1);
    @(negedge clk);
    cyc_start = cs; in_valid = v; in_uops = UOP_W'(u);
    in_begin = b; in_end = e; rob_free = ROB_W'(rob); rf_ok = rf; nxt_ok = nx;
    #1;
  endtask

  task automatic t_reset();
    put(0, 1, 4);
    chk("R1 full width after reset", int'(disp), 1);
    chk("R1 uops after reset", int'(disp_uops), 4);
    chk("R1 no carry after reset", int'(carry_vld), 0);
    put(0, 1, 1);
    chk("R3 no slot left", int'(in_ready), 0);
    chk("R9 slot refusal has no stall", int'(stall), 0);
  endtask

  task automatic t_pack();
    put(1, 1, 2);
    chk("R2 fresh cycle accepts", int'(disp), 1);
    chk("R2 no carry report", int'(carry_vld), 0);
    put(0, 1, 2);
    chk("R3 exact fit", int'(disp), 1);
    put(0, 1, 1);
    chk("R3 overrun refused", int'(in_ready), 0);
    put(1, 1, 3);
    chk("R11 disp_uops", int'(disp_uops), 3);
    put(0, 1, 1);
    chk("R3 last slot", int'(disp), 1);
    put(0, 0, 1);
    chk("R11 idle no disp", int'(disp), 0);
    chk("R11 idle uops zero", int'(disp_uops), 0);
  endtask

  task automatic t_begin();
    put(1, 1, 1);
    chk("R4 plain first", int'(disp), 1);
    put(0, 1, 1, 1'b1);
    chk("R4 begin refused mid cycle", int'(in_ready), 0);
    put(1, 1, 1, 1'b1);
    chk("R4 begin accepted fresh", int'(disp), 1);
  endtask

  task automatic t_end();
    put(1, 1, 1, 1'b0, 1'b1);
    chk("R5 end accepted", int'(disp), 1);
    put(0, 1, 1);
    chk("R5 slots closed", int'(in_ready), 0);
  endtask

  task automatic t_carry();
    put(1, 1, 10);
    chk("R6 oversize accepted", int'(disp), 1);
    chk("R6 reports width", int'(disp_uops), 4);
    put(0, 1, 1);
    chk("R8 blocked while pending", int'(in_ready), 0);
    put(1, 1, 1);
    chk("R7 carry reported", int'(carry_vld), 1);
    chk("R7 carry uops capped", int'(carry_uops), 4);
    chk("R8 still pending", int'(in_ready), 0);
    put(1, 1, 1);
    chk("R7 residue reported", int'(carry_uops), 2);
    chk("R8 released", int'(disp), 1);
    put(0, 1, 1);
    chk("R7 second slot", int'(disp), 1);
    put(0, 1, 1);
    chk("R7 only two slots", int'(in_ready), 0);
    put(1, 1, 1);
    chk("R6 prefill", int'(disp), 1);
    put(0, 1, 6);
    chk("R6 oversize needs empty cycle", int'(in_ready), 0);
    put(1, 1, 5);
    chk("R6 carry one", int'(disp_uops), 4);
    put(1, 1, 3);
    chk("R7 carry one report", int'(carry_uops), 1);
    chk("R7 three slots left", int'(disp_uops), 3);
  endtask

  task automatic t_stall();
    put(1, 1, 3, 1'b0, 1'b0, 2, 1'b0, 1'b0);
    chk("R9 retire first", int'(stall), 1);
    chk("R9 no dispatch", int'(disp), 0);
    put(1, 1, 3, 1'b0, 1'b0, 3, 1'b0, 1'b0);
    chk("R9 registers second", int'(stall), 2);
    put(1, 1, 3, 1'b0, 1'b0, 3, 1'b1, 1'b0);
    chk("R9 next stage third", int'(stall), 3);
    put(1, 0, 3, 1'b0, 1'b0, 3, 1'b1, 1'b0);
    chk("R9 no valid no stall", int'(stall), 0);
    put(1, 1, 4);
    chk("R9 clean dispatch", int'(stall), 0);
    put(0, 1, 1, 1'b0, 1'b0, 63, 1'b1, 1'b0);
    chk("R9 slot refusal masks stall", int'(stall), 0);
    put(1, 1, 6, 1'b0, 1'b0, 5);
    chk("R10 full count compared", int'(stall), 1);
    put(1, 1, 6, 1'b0, 1'b0, 6);
    chk("R10 exact room", int'(disp), 1);
    put(1, 0, 1);
    chk("R7 drain two", int'(carry_uops), 2);
    put(0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pack();
    t_begin();
    t_end();
    t_carry();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule